// File: doc/BRIEF.md
# Code Readback Protection Unit

This block sits between on-chip program storage and every path that can read, rewrite or bypass it. It takes three stored lock bits and decodes them into one of four cumulative protection levels. Each level removes one more capability, in a fixed order: reading internal code from an external table fetch, programming, latching of the external-access strap, then verify readback, and at the last level external execution. When a verify readback is allowed, each code byte is scrambled with a 64-entry key table. The low index bits of the verify address pick the key byte, and the result is the XNOR of code byte and key byte.

Verify readback is a stream. Requests enter on a valid/ready port and results leave through one registered output stage, also valid/ready. Back-pressure works as follows. A result is held, unchanged, while `rd_valid` is high and `rd_ready` is low. The input reports `vfy_ready` high only when the output register is empty or is being drained in the same cycle. The table-fetch, programming and external-execution requests are plain combinational qualifiers, each with a grant/deny pair. The external-access strap is sampled on every reset cycle. Once any lock is in force, the captured value replaces the live pin.

Top module: `cp_protect_unit`

## Requirements
- R1: With lock level open or first level, an accepted verify request returns `rd_data = ~(vfy_code ^ key[idx])` with `rd_denied = 0`, where key byte i sits at `enc_table[8*i+7:8*i]`.
- R2: A key table of all ones returns the code byte unchanged, and a code byte of 0xFF returns the selected key byte itself.
- R3: The key index is `vfy_addr[5:0]`, and address bits above bit 5 have no effect on the result.
- R4: A request is accepted when `vfy_valid && vfy_ready`. Its result appears with `rd_valid` high one clock later. `vfy_ready = !rd_valid || rd_ready`, and a pending result holds stable while `rd_ready` is low.
- R5: A lock bit is programmed when 0. `lock_bits[0]` is the first lock, `lock_bits[1]` the second and `lock_bits[2]` the third. 3'b111 means open, 3'b110 first level, 3'b100 second level and 3'b000 full lock.
- R6: Table-fetch (`movc_*`) and programming (`prog_*`) requests are granted only at the open level and are denied at every other level.
- R7: At the second level and above, a verify result carries `rd_data = 8'h00` and `rd_denied = 1`.
- R8: External-execution requests are granted at every level except full lock.
- R9: Any lock-bit pattern other than the four in R5 behaves as full lock.
- R10: `ea_eff` follows `ea_pin` at the open level. At any other level it shows the value `ea_pin` had during the last reset cycle.
- R11: During reset `rd_valid` clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also the strap capture window |
| lock_bits | input | 3 | Stored lock bits, 0 = programmed |
| enc_table | input | 512 | Key table, byte i at bits 8i+7..8i |
| ea_pin | input | 1 | External-access strap pin |
| ea_eff | output | 1 | Effective external-access value |
| vfy_valid | input | 1 | Verify request valid |
| vfy_ready | output | 1 | Verify request accepted this cycle when valid |
| vfy_addr | input | 16 | Verify address |
| vfy_code | input | 8 | Raw code byte at that address |
| rd_valid | output | 1 | Verify result valid |
| rd_ready | input | 1 | Consumer ready for result |
| rd_data | output | 8 | Scrambled byte or fixed deny value |
| rd_denied | output | 1 | Result was refused by the lock |
| movc_req | input | 1 | External table-fetch of internal code requested |
| movc_grant | output | 1 | Table fetch allowed |
| movc_deny | output | 1 | Table fetch refused |
| prog_req | input | 1 | Programming requested |
| prog_grant | output | 1 | Programming allowed |
| prog_deny | output | 1 | Programming refused |
| exec_req | input | 1 | External execution requested |
| exec_grant | output | 1 | External execution allowed |
| exec_deny | output | 1 | External execution refused |

## Verification
The assertions assume that the lock bits and key table change only between transactions. The assumption matters because a result is judged against the level in force when it was accepted. The assertions also assume that reset lasts at least one clock, so that the strap capture has a prior cycle to refer to. The bench changes `lock_bits` only at falling edges while no request is in flight. It holds reset for several cycles before each release and drives the consumer's `rd_ready` only at falling edges, which keeps the hold checks meaningful.

// File: rtl/cp_lock_pkg.sv
package cp_lock_pkg;
  typedef enum logic [1:0] {
    LVL_OPEN   = 2'd0,
    LVL_FETCH  = 2'd1,
    LVL_NOREAD = 2'd2,
    LVL_FULL   = 2'd3
  } lock_level_e;

  typedef struct packed {
    logic fetch_ok;
    logic prog_ok;
    logic read_ok;
    logic exec_ok;
    logic strap_hold;
  } caps_t;
endpackage

// File: rtl/cp_lock_decode.sv
module cp_lock_decode
  import cp_lock_pkg::*;
(
  input  logic [2:0] lock_bits,
  output caps_t      caps
);
  lock_level_e level;

  // R5 encoding, R9 fallback to the most restrictive level
  always_comb begin
    unique case (lock_bits)
      3'b111:  level = LVL_OPEN;
      3'b110:  level = LVL_FETCH;
      3'b100:  level = LVL_NOREAD;
      default: level = LVL_FULL;
    endcase
  end

  always_comb begin
    caps.fetch_ok   = (level == LVL_OPEN);
    caps.prog_ok    = (level == LVL_OPEN);
    caps.strap_hold = (level != LVL_OPEN);
    caps.read_ok    = (level == LVL_OPEN) || (level == LVL_FETCH);
    caps.exec_ok    = (level != LVL_FULL);
  end
endmodule

// File: rtl/cp_key_select.sv
module cp_key_select #(
  parameter int DEPTH = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH*8-1:0] table_flat,
  input  logic [IDX_W-1:0]   idx,
  output logic [7:0]         key
);
  logic [7:0] entries [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_unpack
    assign entries[g] = table_flat[g*8 +: 8];
  end

  assign key = entries[idx];
endmodule

// File: rtl/cp_read_stage.sv
module cp_read_stage #(
  parameter logic [7:0] DENY_BYTE = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] code,
  input  logic [7:0] key,
  input  logic       allow,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_denied
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= 8'h00;
      out_denied <= 1'b0;
    end else begin
      if (take) begin
        out_valid  <= 1'b1;
        out_data   <= allow ? ~(code ^ key) : DENY_BYTE;
        out_denied <= !allow;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cp_protect_unit.sv
module cp_protect_unit
  import cp_lock_pkg::*;
#(
  parameter int         ADDR_W    = 16,
  parameter int         TBL_DEPTH = 64,
  parameter logic [7:0] DENY_BYTE = 8'h00,
  localparam int        IDX_W     = $clog2(TBL_DEPTH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2:0]             lock_bits,
  input  logic [TBL_DEPTH*8-1:0] enc_table,
  input  logic                   ea_pin,
  output logic                   ea_eff,
  input  logic                   vfy_valid,
  output logic                   vfy_ready,
  input  logic [ADDR_W-1:0]      vfy_addr,
  input  logic [7:0]             vfy_code,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic [7:0]             rd_data,
  output logic                   rd_denied,
  input  logic                   movc_req,
  output logic                   movc_grant,
  output logic                   movc_deny,
  input  logic                   prog_req,
  output logic                   prog_grant,
  output logic                   prog_deny,
  input  logic                   exec_req,
  output logic                   exec_grant,
  output logic                   exec_deny
);
  caps_t      caps;
  logic [7:0] key;
  logic       ea_q;
  logic       unused_addr_hi;

  assign unused_addr_hi = ^vfy_addr[ADDR_W-1:IDX_W];

  cp_lock_decode u_dec (
    .lock_bits (lock_bits),
    .caps      (caps)
  );

  cp_key_select #(.DEPTH(TBL_DEPTH)) u_key (
    .table_flat (enc_table),
    .idx        (vfy_addr[IDX_W-1:0]),
    .key        (key)
  );

  cp_read_stage #(.DENY_BYTE(DENY_BYTE)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (vfy_valid),
    .in_ready   (vfy_ready),
    .code       (vfy_code),
    .key        (key),
    .allow      (caps.read_ok),
    .out_valid  (rd_valid),
    .out_ready  (rd_ready),
    .out_data   (rd_data),
    .out_denied (rd_denied)
  );

  // strap sampled on every reset cycle, held afterwards
  always_ff @(posedge clk) begin
    if (!rst_n) ea_q <= ea_pin;
  end

  assign ea_eff     = caps.strap_hold ? ea_q : ea_pin;
  assign movc_grant = movc_req &&  caps.fetch_ok;
  assign movc_deny  = movc_req && !caps.fetch_ok;
  assign prog_grant = prog_req &&  caps.prog_ok;
  assign prog_deny  = prog_req && !caps.prog_ok;
  assign exec_grant = exec_req &&  caps.exec_ok;
  assign exec_deny  = exec_req && !caps.exec_ok;
endmodule

// File: rtl/cp_protect_checker.sv
module cp_protect_checker #(
  parameter logic [7:0] DENY_BYTE = 8'h00
) (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] lock_bits,
  input logic       vfy_valid,
  input logic       vfy_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       rd_denied,
  input logic       movc_req,
  input logic       movc_grant,
  input logic       prog_grant,
  input logic       exec_req,
  input logic       exec_grant,
  input logic       ea_eff
);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_denied));

  p_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    vfy_valid && vfy_ready |=> rd_valid);

  p_deny_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_denied |-> rd_data == DENY_BYTE);

  p_cumulative_r8: assert property (@(posedge clk) disable iff (!rst_n)
    movc_req && exec_req && movc_grant |-> exec_grant);

  p_prog_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_grant |-> lock_bits == 3'b111);

  p_strap_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    lock_bits != 3'b111 && $past(lock_bits != 3'b111) && $past(rst_n) |-> $stable(ea_eff));

  p_reset_r11: assert property (@(posedge clk)
    !rst_n |=> !rd_valid);
endmodule

bind cp_protect_unit cp_protect_checker #(.DENY_BYTE(DENY_BYTE)) u_chk (.*);

// File: tb/tb_cp_protect_unit.sv
module tb_cp_protect_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [2:0]   lock_bits;
  logic [511:0] enc_table;
  logic         ea_pin, ea_eff;
  logic         vfy_valid, vfy_ready;
  logic [15:0]  vfy_addr;
  logic [7:0]   vfy_code;
  logic         rd_valid, rd_ready, rd_denied;
  logic [7:0]   rd_data;
  logic         movc_req, movc_grant, movc_deny;
  logic         prog_req, prog_grant, prog_deny;
  logic         exec_req, exec_grant, exec_deny;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  cp_protect_unit dut (.*);

  function automatic logic [7:0] key_of(int i);
    return 8'((i * 37 + 11) ^ (i << 3));
  endfunction

  function automatic logic [511:0] scrambled_table();
    logic [511:0] t;
    for (int i = 0; i < 64; i++) t[i*8 +: 8] = key_of(i);
    return t;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst_n = 1'b0; ea_pin = strap;
    vfy_valid = 0; rd_ready = 1; movc_req = 0; prog_req = 0; exec_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic one_verify(input logic [15:0] a, input logic [7:0] c,
                            input logic [7:0] exp_d, input logic exp_den, input string req);
    @(negedge clk);
    vfy_addr = a; vfy_code = c; vfy_valid = 1; rd_ready = 1;
    @(negedge clk);
    vfy_valid = 0;
    check(rd_valid == 1'b1, req, rd_valid, 1);
    check(rd_data == exp_d && rd_denied == exp_den, req, {rd_denied, rd_data}, {exp_den, exp_d});
  endtask

  task automatic t_reset();
    do_reset(1'b0);
    check(rd_valid == 1'b0, "R11", rd_valid, 0);
  endtask

  task automatic t_open_scramble();
    lock_bits = 3'b111; enc_table = scrambled_table();
    one_verify(16'h0005, 8'h3C, ~(8'h3C ^ key_of(5)), 0, "R1");
    one_verify(16'h003F, 8'hA7, ~(8'hA7 ^ key_of(63)), 0, "R1");
    lock_bits = 3'b110;  // first level still allows verify
    one_verify(16'h0011, 8'h00, ~key_of(17), 0, "R1");
    lock_bits = 3'b111;
  endtask

  task automatic t_erased_and_ff();
    enc_table = '1;
    one_verify(16'h0123, 8'h5A, 8'h5A, 0, "R2");
    enc_table = scrambled_table();
    one_verify(16'h0009, 8'hFF, key_of(9), 0, "R2");
  endtask

  task automatic t_index_bits();
    one_verify(16'hFFC7, 8'h81, ~(8'h81 ^ key_of(7)), 0, "R3");
    one_verify(16'h1E07, 8'h81, ~(8'h81 ^ key_of(7)), 0, "R3");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    rd_ready = 0; vfy_addr = 16'h0002; vfy_code = 8'h10; vfy_valid = 1;
    @(negedge clk);
    vfy_code = 8'h20; vfy_addr = 16'h0003;
    check(vfy_ready == 1'b0, "R4", vfy_ready, 0);
    repeat (2) @(negedge clk);
    check(rd_valid && rd_data == ~(8'h10 ^ key_of(2)), "R4", rd_data, ~(8'h10 ^ key_of(2)));
    rd_ready = 1;
    #1 check(vfy_ready == 1'b1, "R4", vfy_ready, 1);
    @(negedge clk);
    vfy_valid = 0;
    check(rd_valid && rd_data == ~(8'h20 ^ key_of(3)), "R4", rd_data, ~(8'h20 ^ key_of(3)));
    @(negedge clk);
    check(rd_valid == 1'b0, "R4", rd_valid, 0);
  endtask

  task automatic caps_at(input logic [2:0] lb, input bit f, input bit e, input string req);
    @(negedge clk);
    lock_bits = lb; movc_req = 1; prog_req = 1; exec_req = 1;
    #1;
    check(movc_grant == f && movc_deny == !f, req, {movc_grant, movc_deny}, {f, !f});
    check(prog_grant == f && prog_deny == !f, req, {prog_grant, prog_deny}, {f, !f});
    check(exec_grant == e && exec_deny == !e, req, {exec_grant, exec_deny}, {e, !e});
    movc_req = 0; prog_req = 0; exec_req = 0;
  endtask

  task automatic t_levels();
    caps_at(3'b111, 1, 1, "R6");
    caps_at(3'b110, 0, 1, "R5");
    caps_at(3'b100, 0, 1, "R8");
    caps_at(3'b000, 0, 0, "R8");
    lock_bits = 3'b100;
    one_verify(16'h0004, 8'h66, 8'h00, 1, "R7");
    lock_bits = 3'b000;
    one_verify(16'h0004, 8'h66, 8'h00, 1, "R7");
  endtask

  task automatic t_undefined();
    foreach (lock_bits_list[i]) begin
      caps_at(lock_bits_list[i], 0, 0, "R9");
      one_verify(16'h0001, 8'h12, 8'h00, 1, "R9");
    end
  endtask
  logic [2:0] lock_bits_list [4] = '{3'b101, 3'b011, 3'b010, 3'b001};

  task automatic t_strap();
    lock_bits = 3'b111;
    do_reset(1'b1);
    @(negedge clk);
    ea_pin = 0; #1;
    check(ea_eff == 1'b0, "R10", ea_eff, 0);
    lock_bits = 3'b110; #1;
    check(ea_eff == 1'b1, "R10", ea_eff, 1);
    ea_pin = 1; lock_bits = 3'b111;
    do_reset(1'b0);
    lock_bits = 3'b000;
    @(negedge clk);
    ea_pin = 1; #1;
    check(ea_eff == 1'b0, "R10", ea_eff, 0);
  endtask

  initial begin
    fork
      begin
        rst_n = 0; lock_bits = 3'b111; enc_table = '1; ea_pin = 0;
        vfy_valid = 0; vfy_addr = 0; vfy_code = 0; rd_ready = 1;
        movc_req = 0; prog_req = 0; exec_req = 0;
        t_reset();
        t_open_scramble();
        t_erased_and_ff();
        t_index_bits();
        t_backpressure();
        t_levels();
        t_undefined();
        t_strap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule